// File: doc/BRIEF.md
# Byte-Wide Serial Port Register Bank with Loopback Queue

This block gives a host a byte-wide register window in the manner of a classic PC serial port. A host bus with one-cycle accesses selects one of eight registers: data, interrupt enable, interrupt identification, line control, modem control, line status, modem status and scratch. A bank bit in line control swaps the first two offsets for the two halves of a 16-bit divisor. The divisor is stored and read back but drives nothing. There is no bit engine. A byte written to the data register leaves on a parallel valid/data port in the next cycle. Received bytes arrive on a valid/ready input stream and wait in a 64-entry queue until the host reads them.

When the loopback bit in modem control is set, data writes go into the receive queue instead of the transmit port. The queue is bounded, and a write that finds it full is lost. While loopback is on, the external input stream is accepted and discarded. Interrupt sources are tracked in the identification register. The block drives a level output and a one-cycle pulse for every raise event.

Each access is decoded into one operation of the enumerated type `acc_op_e`. That operation drives every register update:

- `OP_NONE`: no access, or a write with no effect.
- `OP_TX_SEND`: data write with loopback off.
- `OP_LOOP_PUSH`: data write with loopback on.
- `OP_RX_POP`: data read.
- `OP_DIV_LO_WR` and `OP_DIV_HI_WR`: divisor writes.
- `OP_IER_WR`, `OP_LCR_WR`, `OP_MCR_WR` and `OP_SCR_WR`: control and scratch writes.
- `OP_IID_RD`: identification read, which clears.
- `OP_PLAIN_RD`: any read with no side effect.

The identification register moves between its idle value (0x01) and its pending values as follows:

- **Raise**: a transmit or receive event sets a source bit and clears bit 0.
- **Pop clear**: a data read drops bit 2 and returns the register to idle if nothing is left.
- **Read reset**: an identification read returns the register to idle.

Within one cycle the clears are applied first and the raises last. An event that lands in the same cycle as a clear is therefore kept.

Top module: `sport_regbank`

## Requirements
- R1: The register offsets are 0 data, 1 interrupt enable, 2 identification, 3 line control, 4 modem control, 5 line status, 6 modem status and 7 scratch. A read of an offset of 8 or more returns 0x00, and a write there changes nothing. The scratch register holds any byte written to it.
- R2: While line control bit 7 is 1, offsets 0 and 1 read and write the low and high bytes of the divisor. Such a data-offset write emits nothing on the transmit port.
- R3: After reset the registers read as follows: interrupt enable 0x00, identification 0xC1, line control 0x03, modem control 0x08, line status 0x60, modem status 0xB0, scratch 0x00 and divisor 0x000C. At reset `irq_level` is 0 and `rx_ready` is 1.
- R4: A write to interrupt enable stores only bits 3:0. Bit 0 enables the receive interrupt and bit 1 enables the transmit interrupt.
- R5: A data write with loopback (modem control bit 4) clear raises `tx_valid` with the byte for exactly the next cycle. If interrupt enable bit 1 is set, identification bit 1 is set and bit 0 is cleared.
- R6: A data write with loopback set does not transmit. The byte enters the receive queue only if the queue holds fewer than 64 bytes; otherwise it is dropped.
- R7: Each byte accepted into the queue sets line status bit 0. If interrupt enable bit 0 is set, it also sets identification bit 2 and clears bit 0.
- R8: A data read returns the oldest queued byte, or 0x00 when the queue is empty. It clears identification bit 2, and sets bit 0 if no source bit remains. Line status bit 0 clears when the queue held at most one byte before the read.
- R9: An identification read returns the register ORed with 0xC0, then the register becomes 0x01.
- R10: While loopback is set, `rx_ready` is 1 and input bytes are discarded without entering the queue.
- R11: While loopback is clear, `rx_ready` is 0 exactly when the queue holds 64 bytes.
- R12: `irq_level` is 1 while identification bit 0 is 0. `irq_pulse` is 1 for one cycle after every raise event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Access strobe, one cycle per access |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Register offset |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Read byte, valid in the access cycle |
| rx_valid | input | 1 | Input byte offered |
| rx_data | input | 8 | Input byte |
| rx_ready | output | 1 | Input byte taken this cycle when valid |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_data | output | 8 | Transmit byte |
| irq_level | output | 1 | Interrupt pending level |
| irq_pulse | output | 1 | One-cycle pulse per raise event |

## Verification
The assertions assume the following about the host:

- Every access lasts one cycle, and `host_we` and `host_addr` are stable while `host_sel` is high.
- The input stream is sampled only on cycles where ready and valid are both high.

The bench respects these assumptions. Every access is driven on the falling edge for exactly one cycle, and the bench only offers input bytes between host accesses. The queue-bound and pop properties rely on the top level gating queue pushes and pops, so the stimulus fills the queue to 64 and beyond through both paths.

// File: rtl/sport_pkg.sv
package sport_pkg;
    localparam int BYTE_W = 8;

    localparam logic [2:0] OFS_DATA = 3'd0;
    localparam logic [2:0] OFS_IEN  = 3'd1;
    localparam logic [2:0] OFS_IID  = 3'd2;
    localparam logic [2:0] OFS_LCTL = 3'd3;
    localparam logic [2:0] OFS_MCTL = 3'd4;
    localparam logic [2:0] OFS_LSTA = 3'd5;
    localparam logic [2:0] OFS_MSTA = 3'd6;
    localparam logic [2:0] OFS_SCR  = 3'd7;

    localparam logic [7:0] IEN_INIT  = 8'h00;
    localparam logic [7:0] IID_IDLE  = 8'h01;
    localparam logic [7:0] LCTL_INIT = 8'h03;
    localparam logic [7:0] MCTL_INIT = 8'h08;
    localparam logic [7:0] LSTA_BASE = 8'h60;
    localparam logic [7:0] MSTA_CONST = 8'hB0;
    localparam logic [15:0] DIV_INIT = 16'd12;
    localparam logic [7:0] IID_FIXED = 8'hC0;
    localparam logic [7:0] IEN_MASK  = 8'h0F;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_TX_SEND,
        OP_LOOP_PUSH,
        OP_RX_POP,
        OP_DIV_LO_WR,
        OP_DIV_HI_WR,
        OP_IER_WR,
        OP_LCR_WR,
        OP_MCR_WR,
        OP_SCR_WR,
        OP_IID_RD,
        OP_PLAIN_RD
    } acc_op_e;
endpackage

// File: rtl/sport_rxq.sv
module sport_rxq #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             full,
    output logic             empty,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] cnt;

    assign count = cnt;
    assign full  = (cnt == CNT_W'(DEPTH));
    assign empty = (cnt == '0);
    assign dout  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            unique case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (!full || pop));
    assert_pop_nonempty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(DEPTH));
endmodule

// File: rtl/sport_decode.sv
module sport_decode
    import sport_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              sel,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic              dlab,
    input  logic              loop_en,
    output acc_op_e           op
);
    logic       in_range;
    logic [2:0] ofs;

    assign in_range = (addr < ADDR_W'(8));
    assign ofs      = addr[2:0];

    always_comb begin
        op = OP_NONE;
        if (sel && in_range && we) begin
            unique case (ofs)
                OFS_DATA: op = dlab ? OP_DIV_LO_WR : (loop_en ? OP_LOOP_PUSH : OP_TX_SEND);
                OFS_IEN:  op = dlab ? OP_DIV_HI_WR : OP_IER_WR;
                OFS_LCTL: op = OP_LCR_WR;
                OFS_MCTL: op = OP_MCR_WR;
                OFS_SCR:  op = OP_SCR_WR;
                default:  op = OP_NONE;
            endcase
        end else if (sel && !we) begin
            op = OP_PLAIN_RD;
            if (in_range && ofs == OFS_DATA && !dlab) op = OP_RX_POP;
            if (in_range && ofs == OFS_IID)           op = OP_IID_RD;
        end
    end
endmodule

// File: rtl/sport_intid.sv
module sport_intid
    import sport_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_reset,
    input  logic       pop_clear,
    input  logic       tx_raise,
    input  logic       rx_raise,
    output logic [7:0] iid,
    output logic       irq_pulse
);
    logic [7:0] iid_q, iid_d;

    always_comb begin
        iid_d = iid_q;
        if (rd_reset) iid_d = IID_IDLE;
        if (pop_clear) begin
            iid_d[2] = 1'b0;
            if (iid_d == 8'h00) iid_d = IID_IDLE;
        end
        if (tx_raise) begin
            iid_d[0] = 1'b0;
            iid_d[1] = 1'b1;
        end
        if (rx_raise) begin
            iid_d[0] = 1'b0;
            iid_d[2] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iid_q     <= IID_IDLE;
            irq_pulse <= 1'b0;
        end else begin
            iid_q     <= iid_d;
            irq_pulse <= tx_raise | rx_raise;
        end
    end

    assign iid = iid_q;

    assert_pulse_sets_level_R12: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> !iid_q[0]);
    assert_read_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_reset && !tx_raise && !rx_raise) |=> (iid_q == IID_IDLE));
    assert_pop_clears_rx_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_clear && !rx_raise) |=> !iid_q[2]);
endmodule

// File: rtl/sport_regbank.sv
module sport_regbank
    import sport_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int Q_DEPTH = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sel,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              irq_level,
    output logic              irq_pulse
);
    localparam int CNT_W = $clog2(Q_DEPTH+1);

    logic [7:0]  ien_q, lctl_q, mctl_q, scr_q;
    logic [15:0] div_q;
    logic        lsta_rx_q;
    logic [7:0]  iid;
    acc_op_e     op;

    logic dlab, loop_en;
    logic q_full, q_empty, q_push, q_pop;
    logic [7:0] q_dout, q_din;
    logic [CNT_W-1:0] q_count;
    logic ext_take, loop_take;
    logic tx_raise, rx_raise;

    assign dlab    = lctl_q[7];
    assign loop_en = mctl_q[4];

    sport_decode #(.ADDR_W(ADDR_W)) u_dec (
        .sel(host_sel), .we(host_we), .addr(host_addr),
        .dlab(dlab), .loop_en(loop_en), .op(op)
    );

    assign rx_ready  = loop_en | ~q_full;
    assign ext_take  = rx_valid & ~loop_en & ~q_full;
    assign loop_take = (op == OP_LOOP_PUSH) & ~q_full;
    assign q_push    = ext_take | loop_take;
    assign q_din     = loop_take ? host_wdata : rx_data;
    assign q_pop     = (op == OP_RX_POP) & ~q_empty;

    sport_rxq #(.DEPTH(Q_DEPTH), .WIDTH(BYTE_W)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(q_push), .din(q_din),
        .pop(q_pop), .dout(q_dout), .full(q_full), .empty(q_empty),
        .count(q_count)
    );

    assign tx_raise = (op == OP_TX_SEND) & ien_q[1];
    assign rx_raise = q_push & ien_q[0];

    sport_intid u_iid (
        .clk(clk), .rst_n(rst_n),
        .rd_reset(op == OP_IID_RD),
        .pop_clear(op == OP_RX_POP),
        .tx_raise(tx_raise), .rx_raise(rx_raise),
        .iid(iid), .irq_pulse(irq_pulse)
    );

    assign irq_level = ~iid[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q  <= IEN_INIT;
            lctl_q <= LCTL_INIT;
            mctl_q <= MCTL_INIT;
            scr_q  <= 8'h00;
            div_q  <= DIV_INIT;
        end else begin
            unique case (op)
                OP_DIV_LO_WR: div_q[7:0]  <= host_wdata;
                OP_DIV_HI_WR: div_q[15:8] <= host_wdata;
                OP_IER_WR:    ien_q       <= host_wdata & IEN_MASK;
                OP_LCR_WR:    lctl_q      <= host_wdata;
                OP_MCR_WR:    mctl_q      <= host_wdata;
                OP_SCR_WR:    scr_q       <= host_wdata;
                default:      ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lsta_rx_q <= 1'b0;
            tx_valid  <= 1'b0;
            tx_data   <= 8'h00;
        end else begin
            if (q_push)
                lsta_rx_q <= 1'b1;
            else if (op == OP_RX_POP && q_count <= CNT_W'(1))
                lsta_rx_q <= 1'b0;
            tx_valid <= (op == OP_TX_SEND);
            if (op == OP_TX_SEND) tx_data <= host_wdata;
        end
    end

    always_comb begin
        host_rdata = 8'h00;
        if (host_sel && !host_we && host_addr < ADDR_W'(8)) begin
            unique case (host_addr[2:0])
                OFS_DATA: host_rdata = dlab ? div_q[7:0] : (q_empty ? 8'h00 : q_dout);
                OFS_IEN:  host_rdata = dlab ? div_q[15:8] : ien_q;
                OFS_IID:  host_rdata = iid | IID_FIXED;
                OFS_LCTL: host_rdata = lctl_q;
                OFS_MCTL: host_rdata = mctl_q;
                OFS_LSTA: host_rdata = LSTA_BASE | {7'd0, lsta_rx_q};
                OFS_MSTA: host_rdata = MSTA_CONST;
                OFS_SCR:  host_rdata = scr_q;
                default:  host_rdata = 8'h00;
            endcase
        end
    end

    assert_tx_only_after_send_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> $past(host_sel && host_we && !loop_en && !dlab));
    assert_push_sets_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
        q_push |=> lsta_rx_q);
    assert_loop_ignores_input_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_en && op != OP_LOOP_PUSH) |-> !q_push);
    assert_ien_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(op == OP_IER_WR) |-> (ien_q[7:4] == 4'h0));
endmodule

// File: tb/sport_regbank_tb.sv
module sport_regbank_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_sel = 1'b0, host_we = 1'b0;
    logic [3:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_ready, tx_valid, irq_level, irq_pulse;
    logic [7:0] tx_data;
    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    sport_regbank u_dut (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data),
        .irq_level(irq_level), .irq_pulse(irq_pulse)
    );

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] d);
        @(negedge clk);
        host_sel = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_sel = 1'b0; host_we = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        host_sel = 1'b1; host_we = 1'b0; host_addr = a;
        #1 d = host_rdata;
        @(negedge clk);
        host_sel = 1'b0;
    endtask

    task automatic rx_push(logic [7:0] d, output logic rdy, output logic pulse);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = d;
        #1 rdy = rx_ready;
        @(negedge clk);
        rx_valid = 1'b0;
        pulse = irq_pulse;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        check("R3 irq_level", irq_level, 0);
        check("R3 rx_ready", rx_ready, 1);
        rd(1, v); check("R3 ien", v, 8'h00);
        rd(2, v); check("R3 iid", v, 8'hC1);
        rd(3, v); check("R3 lctl", v, 8'h03);
        rd(4, v); check("R3 mctl", v, 8'h08);
        rd(5, v); check("R3 lsta", v, 8'h60);
        rd(6, v); check("R3 msta", v, 8'hB0);
        rd(7, v); check("R3 scr", v, 8'h00);
        rd(0, v); check("R8 empty read", v, 8'h00);
    endtask

    task automatic t_map;
        logic [7:0] v;
        wr(7, 8'hA5); rd(7, v); check("R1 scratch", v, 8'hA5);
        rd(8, v);  check("R1 unmapped read 8", v, 8'h00);
        wr(15, 8'h5A); rd(15, v); check("R1 unmapped read 15", v, 8'h00);
        wr(15, 8'h00); rd(7, v); check("R1 write past range", v, 8'hA5);
        wr(5, 8'hFF); rd(5, v); check("R1 status not writable", v, 8'h60);
    endtask

    task automatic t_divisor;
        logic [7:0] v;
        wr(3, 8'h80);
        rd(0, v); check("R3 div lo", v, 8'h0C);
        rd(1, v); check("R3 div hi", v, 8'h00);
        wr(0, 8'h12);
        check("R2 no tx in bank", tx_valid, 0);
        wr(1, 8'h34);
        rd(3, v); check("R2 lctl", v, 8'h80);
        rd(0, v); check("R2 div lo", v, 8'h12);
        rd(1, v); check("R2 div hi", v, 8'h34);
        wr(3, 8'h03);
        rd(1, v); check("R2 ien visible again", v, 8'h00);
    endtask

    task automatic t_ien;
        logic [7:0] v;
        wr(1, 8'hFF); rd(1, v); check("R4 mask", v, 8'h0F);
        wr(1, 8'h00);
    endtask

    task automatic t_tx;
        logic [7:0] v;
        wr(0, 8'h3C);
        check("R5 tx_valid", tx_valid, 1);
        check("R5 tx_data", tx_data, 8'h3C);
        check("R5 no irq when off", irq_level, 0);
        @(negedge clk);
        check("R5 one cycle", tx_valid, 0);
        wr(1, 8'h02);
        wr(0, 8'h5A);
        check("R5 tx_data 2", tx_data, 8'h5A);
        check("R12 pulse", irq_pulse, 1);
        check("R12 level", irq_level, 1);
        @(negedge clk);
        check("R12 pulse one cycle", irq_pulse, 0);
        rd(2, v); check("R9 iid tx", v, 8'hC2);
        check("R9 level after read", irq_level, 0);
        rd(2, v); check("R9 iid idle", v, 8'hC1);
        wr(1, 8'h00);
    endtask

    task automatic t_rx_fill;
        logic [7:0] v;
        logic r, p;
        wr(1, 8'h01);
        for (int i = 0; i < 64; i++) begin
            rx_push(8'h40 + 8'(i), r, p);
            if (i == 0) begin
                check("R7 first accepted ready", r, 1);
                check("R7 rx pulse", p, 1);
            end
            if (i == 63) check("R11 ready before last", r, 1);
        end
        check("R11 ready low when full", rx_ready, 0);
        rx_push(8'hEE, r, p);
        check("R11 extra refused", r, 0);
        rd(5, v); check("R7 lsta data", v, 8'h61);
        rd(2, v); check("R7 iid rx", v, 8'hC4);
        for (int i = 0; i < 64; i++) begin
            rd(0, v);
            check("R8 order", v, 8'h40 + 8'(i));
            if (i == 0) check("R11 ready after pop", rx_ready, 1);
            if (i == 62) begin
                rd(5, v); check("R8 lsta with one left", v, 8'h61);
            end
        end
        rd(5, v); check("R8 lsta cleared", v, 8'h60);
        rd(0, v); check("R8 empty read", v, 8'h00);
        wr(1, 8'h00);
    endtask

    task automatic t_pop_clear;
        logic [7:0] v;
        logic r, p;
        wr(1, 8'h03);
        wr(0, 8'h11);
        rx_push(8'h22, r, p);
        rd(0, v); check("R8 pop value", v, 8'h22);
        check("R12 level kept by tx", irq_level, 1);
        rd(2, v); check("R8 bit2 cleared", v, 8'hC2);
        wr(1, 8'h01);
        rx_push(8'h33, r, p);
        rd(0, v); check("R8 pop value 2", v, 8'h33);
        check("R8 idle after pop", irq_level, 0);
        wr(1, 8'h00);
    endtask

    task automatic t_loop;
        logic [7:0] v;
        logic r, p;
        wr(4, 8'h10);
        rd(4, v); check("R6 mctl", v, 8'h10);
        rd(6, v); check("R6 msta", v, 8'hB0);
        rx_push(8'hEE, r, p);
        check("R10 ready in loop", r, 1);
        rd(5, v); check("R10 input discarded", v, 8'h60);
        for (int i = 0; i < 65; i++) begin
            wr(0, 8'(i));
            if (tx_valid) check("R6 no tx in loop", tx_valid, 0);
        end
        check("R10 ready while full", rx_ready, 1);
        rd(5, v); check("R6 lsta", v, 8'h61);
        wr(4, 8'h08);
        check("R11 ready low full", rx_ready, 0);
        for (int i = 0; i < 64; i++) begin
            rd(0, v);
            check("R6 loop order", v, 8'(i));
        end
        rd(0, v); check("R6 65th dropped", v, 8'h00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_map;
        t_divisor;
        t_ien;
        t_tx;
        t_rx_fill;
        t_pop_clear;
        t_loop;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule